// File: doc/BRIEF.md
# Sequential radix-2 Booth multiplier

This block multiplies two signed two's complement operands of `W` bits each and returns their full `2W`-bit signed product. It retires one multiplier bit per clock. Each bit is paired with the bit below it, and that pair chooses whether the multiplicand is added to the upper half of an accumulating register, subtracted from it, or skipped. The whole register then shifts right by one place with sign extension. Positive and negative operands go through exactly the same steps, so no separate sign fix-up is needed at the end.

A client drives both operands and pulses `start_i` while the unit is idle. `busy_o` is high for `W` cycles. A one-cycle `done_o` pulse then marks the new value on `product_o`, and that value is held until the next operation completes. A start request that arrives while the unit is busy is dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: When `start_i` is high at a rising edge while `busy_o` is low, the operands are captured at that edge and `busy_o` is high for the next `W` cycles.
- R3: `done_o` is high for exactly one cycle, `W+1` rising edges after the edge that accepted the start. `busy_o` is low in that cycle.
- R4: In the cycle that `done_o` is high, `product_o` equals the signed product of the captured multiplicand and multiplier, as a `2W`-bit two's complement value.
- R5: Mixed signs give correct results. For `W=8`: 76·119 = 9044, 76·(−119) = −9044 and (−76)·(−119) = 9044.
- R6: A multiplier of all ones (−1) gives the negated multiplicand. For example, 0x4C·0xFF = 0xFFB4.
- R7: The most negative multiplicand times the most negative multiplier gives +2^(2W−2). For `W=8` this is 0x80·0x80 = 0x4000.
- R8: A `start_i` pulse while `busy_o` is high has no effect. The running result and the timing of its `done_o` are unchanged, and no second `done_o` follows.
- R9: `product_o` stays unchanged at every edge except the one that raises `done_o`, even when the operand inputs change.
- R10: A zero in either operand gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| mcand_i | input | W | Multiplicand, two's complement |
| mplier_i | input | W | Multiplier, two's complement |
| busy_o | output | 1 | High while the steps are running |
| done_o | output | 1 | One-cycle pulse when a new product is ready |
| product_o | output | 2W | Registered signed product |

## Verification
The start request is driven on a falling edge, so the rising edge that accepts it is known exactly. All outputs are sampled on later falling edges, counted from that edge. `busy_o` is checked high one to `W` edges after acceptance. `done_o` and `product_o` are checked at edge `W+1`, and `done_o` is checked low again at edge `W+2`. For the dropped start, the bench checks the same `W+1` timing and then confirms that no further `done_o` appears and that `product_o` still holds the first result. For the hold requirement, the operand inputs are changed without a start, and `product_o` is sampled over several idle cycles.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // pair = {current bit, bit to its right}
  function automatic booth_op_e recode_pair(input logic cur, input logic right);
    case ({cur, right})
      2'b01:   recode_pair = OP_ADD;
      2'b10:   recode_pair = OP_SUB;
      default: recode_pair = OP_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      right_i,
  output booth_op_e op_o
);

  always_comb begin
    op_o = recode_pair(cur_i, right_i);
  end

  always_comb begin
    AST_OP_LEGAL: assert (op_o != booth_op_e'(2'd3)); // R4
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  booth_op_e      op_i,
  input  logic [W:0]     acc_i,
  input  logic [W-1:0]   mcand_i,
  output logic [W:0]     sum_o
);

  localparam int AW = W + 1;

  logic [AW-1:0] ext;
  logic [AW-1:0] opnd;
  logic          cin;

  assign ext = {mcand_i[W-1], mcand_i};

  genvar g;
  generate
    for (g = 0; g < AW; g++) begin : g_opnd
      always_comb begin
        case (op_i)
          OP_ADD:  opnd[g] = ext[g];
          OP_SUB:  opnd[g] = ~ext[g];
          default: opnd[g] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign cin   = (op_i == OP_SUB);
  assign sum_o = acc_i + opnd + {{(AW-1){1'b0}}, cin};

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == LAST);
  assign load_o   = start_i && !busy_o;
  assign step_o   = busy_o;
  assign finish_o = busy_o && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R3
  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last) |=> (busy_o && !done_o)); // R8
  AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && last) |=> (done_o && !busy_o)); // R3
  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R2

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);

  localparam int PW = 2 * W;

  logic [W:0]   acc_q;
  logic [W-1:0] mq_q;
  logic         qx_q;
  logic [W-1:0] mcand_q;

  logic         load, step, finish;
  booth_op_e    op;
  logic [W:0]   sum;

  booth_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  booth_recode u_recode (
    .cur_i   (mq_q[0]),
    .right_i (qx_q),
    .op_o    (op)
  );

  booth_addsub #(.W(W)) u_addsub (
    .op_i    (op),
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .sum_o   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mq_q    <= '0;
      qx_q    <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mq_q    <= mplier_i;
      qx_q    <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step) begin
      acc_q <= {sum[W], sum[W:1]};
      mq_q  <= {sum[0], mq_q[W-1:1]};
      qx_q  <= mq_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      product_o <= '0;
    end else if (finish) begin
      product_o <= PW'({sum, mq_q[W-1:1]});
    end
  end

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R9
  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && busy_o) |-> $stable(mcand_q)); // R8

endmodule

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;

  localparam int W  = 8;
  localparam int NV = 12;

  // each entry: {multiplicand, multiplier}
  localparam logic [15:0] VEC [NV] = '{
    16'h4C_77, 16'hB4_77, 16'hB4_89, 16'h4C_FF,
    16'h80_80, 16'h7F_7F, 16'h80_7F, 16'h00_93,
    16'h5A_00, 16'h01_01, 16'hFF_FF, 16'h33_C6
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0;
  logic [W-1:0]   mcand_i = '0;
  logic [W-1:0]   mplier_i = '0;
  logic           busy_o, done_o;
  logic [2*W-1:0] product_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  booth_seq_mult #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full operation with timing checks; the start is accepted at the edge after the call
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [2*W-1:0] exp, input string req);
    @(negedge clk);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", {31'd0, busy_o}, 32'd1);
    for (int c = 2; c <= W; c++) begin
      @(negedge clk);
      check("R2 busy during run", {30'd0, busy_o, done_o}, 32'd2);
    end
    @(negedge clk);
    check("R3 done pulse", {30'd0, busy_o, done_o}, 32'd1);
    check(req, {16'd0, product_o}, {16'd0, exp});
    @(negedge clk);
    check("R3 done low after pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {14'd0, busy_o, done_o, product_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {14'd0, busy_o, done_o, product_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2*W-1:0] e;
      e = 16'($signed(VEC[i][15:8]) * $signed(VEC[i][7:0]));
      run(VEC[i][15:8], VEC[i][7:0], e, "R4 table product");
    end

    run(8'd76, 8'd119, 16'd9044, "R5 76*119");
    run(8'd76, 8'h89, 16'hDCAC, "R5 76*-119");
    run(8'hB4, 8'h89, 16'd9044, "R5 -76*-119");
    run(8'h4C, 8'hFF, 16'hFFB4, "R6 mplier all ones");
    run(8'h80, 8'h80, 16'h4000, "R7 most negative squared");
    run(8'h00, 8'h00, 16'h0000, "R10 zero operands");
    run(8'h6D, 8'h00, 16'h0000, "R10 zero multiplier");

    // R8: a second start during the run is dropped
    @(negedge clk);
    mcand_i = 8'd76; mplier_i = 8'd119; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    mcand_i = 8'd5; mplier_i = 8'd5; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 4; c <= W; c++) @(negedge clk);
    @(negedge clk);
    check("R8 done timing kept", {31'd0, done_o}, 32'd1);
    check("R8 result of first start", {16'd0, product_o}, 32'd9044);
    for (int c = 0; c < W + 2; c++) begin
      @(negedge clk);
      check("R8 no second run", {30'd0, busy_o, done_o}, 32'd0);
    end

    // R9: operand changes without start leave the product alone
    mcand_i = 8'h81; mplier_i = 8'h3C;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R9 product held", {16'd0, product_o}, 32'd9044);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule